// File: doc/BRIEF.md
# Serial Execution Order Checker

This block watches a live stream of completed memory events and judges, one event per clock, whether the stream in arrival order is serial. Each event is a read or a write tagged with a processor id, an address and a data value. A serial stream is one where every read returns the value left by the most recent earlier write to the same address. An address that has not been written since the stream began reads as zero.

The checker keeps a shadow of the last value written to each address and a flag for each address that records whether it has been written at all. The first read that breaks the serial rule sets a sticky violation flag. The block records the position of that read in the stream and the processor that issued it.

The checker also watches for value reuse. It keeps a bitmap over the data space for each address. The first write that stores a value already written to that address sets a sticky ambiguity flag and records the same two details. A synchronous clear starts a new stream from scratch. The block is meant to sit beside a memory subsystem in simulation or emulation as a fast first-pass monitor. It does not search for a reordering of the stream.

Top module: `serial_order_monitor`

## Requirements
- R1: After reset, `viol_o` and `ambig_o` are low, both index outputs and both processor outputs are zero, and every address reads as the value 0.
- R2: A read (`ev_is_write_i` = 0) of an address that has not been written since reset or clear is legal only if its data is 0. Any other data value raises the violation flag.
- R3: A read of a written address is legal only if its data equals the value of the most recent earlier write (`ev_is_write_i` = 1) to that same address. Writes to other addresses do not affect it.
- R4: The processor id of an event does not change the verdict on a read or the ambiguity verdict on a write.
- R5: The violation flag is visible just after the clock edge that accepts the offending read, and it stays set until a clear. `viol_idx_o` holds the 0-based position of that read among the events accepted since reset or clear, and `viol_proc_o` holds its processor id. Later offending reads change neither value.
- R6: A write of a value that was already written to the same address since reset or clear raises the ambiguity flag. The first write of any value to an address, including the value 0, does not raise it.
- R7: The ambiguity flag is sticky in the same way as R5. `ambig_idx_o` and `ambig_proc_o` keep the position and processor id of the first reusing write.
- R8: `clear_i` is synchronous. After the edge where it is high, both flags are low, both indices and both processor outputs are zero, every address reads as 0 again, the reuse bitmaps are empty and positions restart at 0. An event presented in the same cycle as the clear is discarded.
- R9: `ev_ready_o` is always high and one event is accepted per clock. Each event is judged against the effects of every earlier event, including the event accepted in the cycle just before it.
- R10: A cycle with `ev_valid_i` low has no effect: no state changes and the event position does not advance.
- R11: The event position saturates at 65535. Every event from position 65535 onward is reported with index 65535.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous restart of the whole check |
| ev_valid_i | input | 1 | Event present this cycle |
| ev_ready_o | output | 1 | Always high |
| ev_is_write_i | input | 1 | 1 = write, 0 = read |
| ev_proc_i | input | PROC_W (2) | Issuing processor id |
| ev_addr_i | input | ADDR_W (3) | Address of the event |
| ev_data_i | input | DATA_W (4) | Value written or value returned by the read |
| viol_o | output | 1 | Sticky serial-rule violation |
| viol_idx_o | output | 16 | Position of the first violating read |
| viol_proc_o | output | PROC_W (2) | Processor of the first violating read |
| ambig_o | output | 1 | Sticky value-reuse flag |
| ambig_idx_o | output | 16 | Position of the first reusing write |
| ambig_proc_o | output | PROC_W (2) | Processor of the first reusing write |

## Verification
Every verdict is due after exactly one register: an event driven before a rising edge updates the flags, indices and shadow state at that edge. The next event is judged against that updated state in the following cycle. The bench drives each event on the falling edge and pushes one expected record into a queue at the same moment. A monitor pops that record a quarter period after the next rising edge, so every comparison falls in the single cycle where the result first appears. Idle and cleared cycles are checked the same way through the outputs, and back-to-back write/read pairs confirm that the update lands in time for the very next event.

// File: rtl/som_pkg.sv
package som_pkg;

    localparam int unsigned IDX_W   = 16;
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    typedef enum logic {
        EV_READ  = 1'b0,
        EV_WRITE = 1'b1
    } ev_kind_e;

endpackage

// File: rtl/som_shadow.sv
module som_shadow #(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_value_o,
    output logic              rd_written_o
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] val;
        logic [DEPTH-1:0]             written;
    } shadow_s;

    shadow_s state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d.val     = '0;
            state_d.written = '0;
        end else if (wr_en_i) begin
            state_d.val[addr_i]     = wr_data_i;
            state_d.written[addr_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_value_o   = state_q.val[addr_i];
    assign rd_written_o = state_q.written[addr_i];

endmodule

// File: rtl/som_reuse_map.sv
module som_reuse_map #(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              set_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              seen_o
);

    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned VALS  = 1 << DATA_W;

    typedef struct packed {
        logic [DEPTH-1:0][VALS-1:0] seen;
    } map_s;

    map_s state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d.seen = '0;
        end else if (set_en_i) begin
            state_d.seen[addr_i][data_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign seen_o = state_q.seen[addr_i][data_i];

endmodule

// File: rtl/som_first_latch.sv
module som_first_latch #(
    parameter int unsigned IDX_W  = 16,
    parameter int unsigned PROC_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              hit_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [PROC_W-1:0] proc_i,
    output logic              flag_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [PROC_W-1:0] proc_o
);

    typedef struct packed {
        logic              flag;
        logic [IDX_W-1:0]  idx;
        logic [PROC_W-1:0] proc;
    } first_s;

    first_s state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d = '0;
        end else if (hit_i && !state_q.flag) begin
            state_d.flag = 1'b1;
            state_d.idx  = idx_i;
            state_d.proc = proc_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flag_o = state_q.flag;
    assign idx_o  = state_q.idx;
    assign proc_o = state_q.proc;

endmodule

// File: rtl/serial_order_monitor.sv
module serial_order_monitor
    import som_pkg::*;
#(
    parameter int unsigned NUM_PROCS = 4,
    parameter int unsigned ADDR_W    = 3,
    parameter int unsigned DATA_W    = 4,
    localparam int unsigned PROC_W   = (NUM_PROCS > 1) ? $clog2(NUM_PROCS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              ev_valid_i,
    output logic              ev_ready_o,
    input  logic              ev_is_write_i,
    input  logic [PROC_W-1:0] ev_proc_i,
    input  logic [ADDR_W-1:0] ev_addr_i,
    input  logic [DATA_W-1:0] ev_data_i,
    output logic              viol_o,
    output logic [IDX_W-1:0]  viol_idx_o,
    output logic [PROC_W-1:0] viol_proc_o,
    output logic              ambig_o,
    output logic [IDX_W-1:0]  ambig_idx_o,
    output logic [PROC_W-1:0] ambig_proc_o
);

    typedef struct packed {
        logic [IDX_W-1:0] pos;
    } top_s;

    top_s state_d, state_q;

    logic              accept;
    logic              is_write;
    logic              wr_en;
    logic [DATA_W-1:0] last_val;
    logic              was_written;
    logic [DATA_W-1:0] legal_val;
    logic              seen;
    logic              read_bad;
    logic              reuse_hit;

    assign ev_ready_o = 1'b1;
    assign accept     = ev_valid_i && !clear_i;
    assign is_write   = (ev_kind_e'(ev_is_write_i) == EV_WRITE);
    assign wr_en      = accept && is_write;

    som_shadow #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_shadow (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (clear_i),
        .wr_en_i      (wr_en),
        .addr_i       (ev_addr_i),
        .wr_data_i    (ev_data_i),
        .rd_value_o   (last_val),
        .rd_written_o (was_written)
    );

    som_reuse_map #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_reuse (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clear_i),
        .set_en_i (wr_en),
        .addr_i   (ev_addr_i),
        .data_i   (ev_data_i),
        .seen_o   (seen)
    );

    always_comb begin
        legal_val = was_written ? last_val : '0;
        read_bad  = accept && !is_write && (ev_data_i != legal_val);
        reuse_hit = wr_en && seen;
    end

    always_comb begin
        state_d = state_q;
        if (clear_i) begin
            state_d.pos = '0;
        end else if (accept && (state_q.pos != IDX_MAX)) begin
            state_d.pos = state_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    som_first_latch #(
        .IDX_W  (IDX_W),
        .PROC_W (PROC_W)
    ) u_viol (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clear_i),
        .hit_i  (read_bad),
        .idx_i  (state_q.pos),
        .proc_i (ev_proc_i),
        .flag_o (viol_o),
        .idx_o  (viol_idx_o),
        .proc_o (viol_proc_o)
    );

    som_first_latch #(
        .IDX_W  (IDX_W),
        .PROC_W (PROC_W)
    ) u_ambig (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clear_i),
        .hit_i  (reuse_hit),
        .idx_i  (state_q.pos),
        .proc_i (ev_proc_i),
        .flag_o (ambig_o),
        .idx_o  (ambig_idx_o),
        .proc_o (ambig_proc_o)
    );

endmodule

// File: rtl/som_checker.sv
module som_checker #(
    parameter int unsigned PROC_W = 2,
    parameter int unsigned IDX_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear_i,
    input logic              ev_valid_i,
    input logic              ev_is_write_i,
    input logic [PROC_W-1:0] ev_proc_i,
    input logic              viol_o,
    input logic [IDX_W-1:0]  viol_idx_o,
    input logic [PROC_W-1:0] viol_proc_o,
    input logic              ambig_o,
    input logic [IDX_W-1:0]  ambig_idx_o,
    input logic [PROC_W-1:0] ambig_proc_o
);

    a_r5_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_o && !clear_i) |=> (viol_o && $stable(viol_idx_o) && $stable(viol_proc_o)));

    a_r7_ambig_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ambig_o && !clear_i) |=> (ambig_o && $stable(ambig_idx_o) && $stable(ambig_proc_o)));

    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (!viol_o && !ambig_o && viol_idx_o == '0 && ambig_idx_o == '0
                     && viol_proc_o == '0 && ambig_proc_o == '0));

    a_r2_viol_from_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol_o) |-> ($past(ev_valid_i && !ev_is_write_i && !clear_i)
                           && viol_proc_o == $past(ev_proc_i)));

    a_r6_ambig_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ambig_o) |-> ($past(ev_valid_i && ev_is_write_i && !clear_i)
                            && ambig_proc_o == $past(ev_proc_i)));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_valid_i && !clear_i) |=> ($stable(viol_o) && $stable(ambig_o)
                                       && $stable(viol_idx_o) && $stable(ambig_idx_o)));

endmodule

bind serial_order_monitor som_checker #(
    .PROC_W (PROC_W),
    .IDX_W  (som_pkg::IDX_W)
) u_som_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear_i       (clear_i),
    .ev_valid_i    (ev_valid_i),
    .ev_is_write_i (ev_is_write_i),
    .ev_proc_i     (ev_proc_i),
    .viol_o        (viol_o),
    .viol_idx_o    (viol_idx_o),
    .viol_proc_o   (viol_proc_o),
    .ambig_o       (ambig_o),
    .ambig_idx_o   (ambig_idx_o),
    .ambig_proc_o  (ambig_proc_o)
);

// File: tb/serial_order_monitor_bench.sv
module serial_order_monitor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NPROC  = 4;
    localparam int AW     = 3;
    localparam int DW     = 4;
    localparam int PW     = 2;
    localparam int NADDR  = 1 << AW;
    localparam int NVALS  = 1 << DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear_i = 1'b0;
    logic          ev_valid_i = 1'b0;
    logic          ev_ready_o;
    logic          ev_is_write_i = 1'b0;
    logic [PW-1:0] ev_proc_i = '0;
    logic [AW-1:0] ev_addr_i = '0;
    logic [DW-1:0] ev_data_i = '0;
    logic          viol_o;
    logic [15:0]   viol_idx_o;
    logic [PW-1:0] viol_proc_o;
    logic          ambig_o;
    logic [15:0]   ambig_idx_o;
    logic [PW-1:0] ambig_proc_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_order_monitor #(
        .NUM_PROCS (NPROC),
        .ADDR_W    (AW),
        .DATA_W    (DW)
    ) u_serial_order_monitor (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear_i       (clear_i),
        .ev_valid_i    (ev_valid_i),
        .ev_ready_o    (ev_ready_o),
        .ev_is_write_i (ev_is_write_i),
        .ev_proc_i     (ev_proc_i),
        .ev_addr_i     (ev_addr_i),
        .ev_data_i     (ev_data_i),
        .viol_o        (viol_o),
        .viol_idx_o    (viol_idx_o),
        .viol_proc_o   (viol_proc_o),
        .ambig_o       (ambig_o),
        .ambig_idx_o   (ambig_idx_o),
        .ambig_proc_o  (ambig_proc_o)
    );

    typedef struct {
        bit          viol;
        logic [15:0] vidx;
        logic [PW-1:0] vproc;
        bit          amb;
        logic [15:0] aidx;
        logic [PW-1:0] aproc;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    // reference model state, built from the requirements
    int   m_val [NADDR];
    bit   m_wr  [NADDR];
    bit   m_seen[NADDR][NVALS];
    int   m_pos;
    bit   m_viol, m_amb;
    int   m_vidx, m_vproc, m_aidx, m_aproc;

    function automatic void model_clear();
        for (int a = 0; a < NADDR; a++) begin
            m_val[a] = 0;
            m_wr[a]  = 1'b0;
            for (int v = 0; v < NVALS; v++) m_seen[a][v] = 1'b0;
        end
        m_pos = 0; m_viol = 0; m_amb = 0;
        m_vidx = 0; m_vproc = 0; m_aidx = 0; m_aproc = 0;
    endfunction

    function automatic void push_exp(string tag);
        exp_t e;
        e.viol = m_viol; e.vidx = 16'(m_vidx); e.vproc = PW'(m_vproc);
        e.amb  = m_amb;  e.aidx = 16'(m_aidx); e.aproc = PW'(m_aproc);
        e.tag  = tag;
        exp_q.push_back(e);
    endfunction

    task automatic send(input bit w, input int p, input int a, input int d, input string tag);
        int legal;
        @(negedge clk);
        clear_i       = 1'b0;
        ev_valid_i    = 1'b1;
        ev_is_write_i = w;
        ev_proc_i     = PW'(p);
        ev_addr_i     = AW'(a);
        ev_data_i     = DW'(d);
        if (!w) begin
            legal = m_wr[a] ? m_val[a] : 0;
            if (d != legal && !m_viol) begin
                m_viol = 1; m_vidx = m_pos; m_vproc = p;
            end
        end else begin
            if (m_seen[a][d] && !m_amb) begin
                m_amb = 1; m_aidx = m_pos; m_aproc = p;
            end
            m_seen[a][d] = 1'b1;
            m_val[a] = d;
            m_wr[a]  = 1'b1;
        end
        if (m_pos != 65535) m_pos++;
        push_exp(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            clear_i       = 1'b0;
            ev_valid_i    = 1'b0;
            ev_is_write_i = 1'b1;
            ev_proc_i     = PW'(3);
            ev_addr_i     = AW'(1);
            ev_data_i     = DW'(9);
        end
    endtask

    task automatic do_clear(input bit with_event, input string tag);
        @(negedge clk);
        clear_i       = 1'b1;
        ev_valid_i    = with_event;
        ev_is_write_i = 1'b1;
        ev_proc_i     = PW'(1);
        ev_addr_i     = AW'(4);
        ev_data_i     = DW'(9);
        model_clear();
        push_exp(tag);
    endtask

    // monitor: one expected record per accepted cycle, sampled after the edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (viol_o !== e.viol || viol_idx_o !== e.vidx || viol_proc_o !== e.vproc ||
                ambig_o !== e.amb || ambig_idx_o !== e.aidx || ambig_proc_o !== e.aproc) begin
                errors++;
                $display("FAIL %s: got viol=%0b idx=%0d proc=%0d amb=%0b idx=%0d proc=%0d exp viol=%0b idx=%0d proc=%0d amb=%0b idx=%0d proc=%0d",
                         e.tag, viol_o, viol_idx_o, viol_proc_o, ambig_o, ambig_idx_o, ambig_proc_o,
                         e.viol, e.vidx, e.vproc, e.amb, e.aidx, e.aproc);
            end
        end
    end

    task automatic direct_check(input bit ok, input string tag, input string detail);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", tag, detail);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, got hang exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        direct_check(viol_o == 0 && ambig_o == 0 && viol_idx_o == 0 && ambig_idx_o == 0
                     && viol_proc_o == 0 && ambig_proc_o == 0, "R1",
                     $sformatf("got viol=%0b amb=%0b vidx=%0d aidx=%0d exp all zero",
                               viol_o, ambig_o, viol_idx_o, ambig_idx_o));
        // R9: always ready
        direct_check(ev_ready_o == 1'b1, "R9", $sformatf("got ready=%0b exp 1", ev_ready_o));

        // R1 / R2 / R4: unwritten addresses read as zero from any processor
        send(0, 0, 2, 0, "R1 unwritten read 0 p0");
        send(0, 3, 6, 0, "R4 unwritten read 0 p3");
        // R3 / R9: write then read back-to-back
        send(1, 0, 1, 5, "R3 write a1=5");
        send(0, 2, 1, 5, "R9 next-cycle read a1=5");
        send(0, 1, 2, 0, "R3 other address untouched");
        // R10: idle cycles carrying a write pattern must not change anything
        idle(4);
        send(0, 1, 1, 5, "R10 read a1=5 after idle write pattern");
        // R2: nonzero read of unwritten address
        send(0, 2, 3, 7, "R2 unwritten read 7");
        // R5: later offenses do not move the record
        send(0, 0, 1, 4, "R5 second offense keeps first");
        send(0, 1, 1, 5, "R5 legal read keeps flag");
        idle(2);
        send(0, 3, 0, 0, "R5 flag still set");

        // R8: clear with a discarded write to a4=9
        do_clear(1'b1, "R8 clear drops flags");
        send(0, 0, 1, 0, "R8 shadow back to zero");
        send(0, 0, 4, 0, "R8 event with clear discarded");

        // R6 / R7: value reuse
        send(1, 2, 0, 0, "R6 first write of 0 is fine");
        send(1, 2, 0, 3, "R6 write a0=3");
        send(1, 1, 5, 0, "R6 same value other address");
        send(0, 0, 0, 3, "R3 read latest a0=3");
        send(1, 3, 0, 0, "R6 reuse of 0 on a0");
        send(0, 1, 0, 0, "R3 read a0=0 after reuse");
        send(1, 1, 0, 3, "R7 second reuse keeps first");
        send(1, 2, 7, 15, "R6 fresh value elsewhere");
        // R4: wrong read from processor 3 records it; right read from 1 is fine
        send(0, 1, 7, 15, "R4 legal read p1");
        send(0, 3, 7, 14, "R4 bad read p3");
        send(0, 0, 7, 15, "R4 stale flag stays");

        // R11: saturation of the event position
        do_clear(1'b0, "R8 plain clear");
        for (int i = 0; i < 65540; i++) send(0, 0, 0, 0, "R11 filler read");
        send(0, 2, 0, 1, "R11 saturated index");
        send(1, 1, 3, 2, "R11 write after saturation");
        send(1, 0, 3, 2, "R11 reuse at saturated index");

        idle(3);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule